// File: doc/BRIEF.md
# Parallel-Prefix Carry Adder

A purely combinational adder of parameterizable width. It sums two operands and a carry-in, and it returns a sum word and a carry-out. Each bit position first describes its carry behaviour as a two-wire status:
- both wires low means the position kills an incoming carry;
- both wires high means it generates a carry;
- wires that differ mean it propagates the carry from below.

The carry-in is merged into bit 0 before the tree. As a result, bit 0 always enters the network as a fully known generate or kill.

A logarithmic prefix network combines neighbouring statuses until every position holds a status that covers all lower bits. The high wire of that status is the carry into the next position. Each sum bit is then the XOR of its two operand bits and its incoming carry.

A compile-time parameter selects the shape of the network. The Kogge-Stone shape has low fan-out and more cells. The Sklansky shape has fewer cells and high fan-out on its low-order nodes. Both shapes give identical results.

Top module: `kpg_adder`

## Requirements
- R1: For every input, `{cout_o, sum_o}` equals `a_i + b_i + cin_i`, taken as an unsigned sum of WIDTH+1 bits.
- R2: When `a_i ^ b_i` is all ones, so that every position propagates, `cout_o` equals `cin_i` and `sum_o` equals the bitwise inverse of cin replicated across the word.
- R3: When both operands are zero, so that every position kills, `cout_o` is 0 and `sum_o` equals `cin_i` in bit 0 with zeros above.
- R4: When bit WIDTH-1 of both operands is 1, that is, the top position generates, `cout_o` is 1 whatever the lower bits and the carry-in.
- R5: All-ones plus one: with `a_i` all ones and `b_i` = 1, `sum_o` equals `cin_i` (0 or 1) and `cout_o` is 1.
- R6: The Kogge-Stone variant (ARCH = ARCH_KS) and the Sklansky variant (ARCH = ARCH_SK) produce identical outputs for every input.
- R7: Each sum bit i equals a_i[i] ^ b_i[i] ^ c[i], where c[0] = cin_i and c[i] is the arithmetic carry out of bits i-1..0. Every fully combined status is resolved: its two wires are equal.
- R8: At WIDTH = 8, R1 and R6 hold for all 2^17 combinations of operands and carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The block holds no state, so every result is due in the same cycle as the operands that produce it. The driver applies a vector just after a rising edge and queues the expected values. The monitor then compares them at the following falling edge, by which time the network has settled. Each cycle the bench feeds a 16-bit pair of instances (one of each shape) and an 8-bit pair. The 8-bit pair walks all of its combinations exhaustively. The 16-bit pair first takes a fixed set of corner cases and then random operands.

// File: rtl/kpg_adder_pkg.sv
package kpg_adder_pkg;
  typedef enum logic [0:0] {
    ARCH_KS = 1'b0,
    ARCH_SK = 1'b1
  } prefix_arch_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/kpg_status_gen.sv
module kpg_status_gen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  // bit 0 absorbs the carry-in: resolves to 11 or 00
  logic seed;
  assign seed = kpg_adder_pkg::maj3(a_i[0], b_i[0], cin_i);

  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    if (j == 0) begin : g_seed
      assign hi_o[j] = seed;
      assign lo_o[j] = seed;
    end else begin : g_raw
      assign hi_o[j] = a_i[j];
      assign lo_o[j] = b_i[j];
    end
  end
endmodule

// File: rtl/kpg_cell.sv
module kpg_cell (
  input  logic ms_hi_i,
  input  logic ms_lo_i,
  input  logic ls_hi_i,
  input  logic ls_lo_i,
  output logic hi_o,
  output logic lo_o
);
  // K/G above dominates; P above forwards the lower status
  assign hi_o = kpg_adder_pkg::maj3(ms_hi_i, ms_lo_i, ls_hi_i);
  assign lo_o = kpg_adder_pkg::maj3(ms_hi_i, ms_lo_i, ls_lo_i);
endmodule

// File: rtl/kpg_prefix_net.sv
module kpg_prefix_net
  import kpg_adder_pkg::*;
#(
  parameter int           WIDTH = 16,
  parameter prefix_arch_e ARCH  = ARCH_KS
) (
  input  logic [WIDTH-1:0] hi_i,
  input  logic [WIDTH-1:0] lo_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;

  logic [LEVELS:0][WIDTH-1:0] hi_l;
  logic [LEVELS:0][WIDTH-1:0] lo_l;

  assign hi_l[0] = hi_i;
  assign lo_l[0] = lo_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int SPAN = 1 << l;
    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
      localparam int  SK_PART = ((j >> (l + 1)) << (l + 1)) + SPAN - 1;
      localparam bit  SK_MRG  = ((j >> l) & 1) == 1;
      localparam bit  KS_MRG  = j >= SPAN;
      localparam bit  MERGE   = (ARCH == ARCH_KS) ? KS_MRG : SK_MRG;
      localparam int  PART    = (ARCH == ARCH_KS) ? (KS_MRG ? j - SPAN : 0) : SK_PART;
      if (MERGE) begin : g_cell
        kpg_cell u_cell (
          .ms_hi_i (hi_l[l][j]),
          .ms_lo_i (lo_l[l][j]),
          .ls_hi_i (hi_l[l][PART]),
          .ls_lo_i (lo_l[l][PART]),
          .hi_o    (hi_l[l+1][j]),
          .lo_o    (lo_l[l+1][j])
        );
      end else begin : g_pass
        assign hi_l[l+1][j] = hi_l[l][j];
        assign lo_l[l+1][j] = lo_l[l][j];
      end
    end
  end

  assign hi_o = hi_l[LEVELS];
  assign lo_o = lo_l[LEVELS];
endmodule

// File: rtl/kpg_sum_stage.sv
module kpg_sum_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [WIDTH-1:0] pre_hi_i,
  output logic [WIDTH-1:0] sum_o
);
  // carry into bit j is the resolved status of bits j-1..0
  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    if (j == 0) begin : g_lsb
      assign sum_o[j] = a_i[j] ^ b_i[j] ^ cin_i;
    end else begin : g_up
      assign sum_o[j] = a_i[j] ^ b_i[j] ^ pre_hi_i[j-1];
    end
  end
endmodule

// File: rtl/kpg_adder.sv
module kpg_adder
  import kpg_adder_pkg::*;
#(
  parameter int           WIDTH = 16,
  parameter prefix_arch_e ARCH  = ARCH_KS
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] st_hi, st_lo;
  logic [WIDTH-1:0] pre_hi, pre_lo;

  kpg_status_gen #(.WIDTH(WIDTH)) u_status (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .hi_o  (st_hi),
    .lo_o  (st_lo)
  );

  kpg_prefix_net #(.WIDTH(WIDTH), .ARCH(ARCH)) u_prefix (
    .hi_i (st_hi),
    .lo_i (st_lo),
    .hi_o (pre_hi),
    .lo_o (pre_lo)
  );

  kpg_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .a_i      (a_i),
    .b_i      (b_i),
    .cin_i    (cin_i),
    .pre_hi_i (pre_hi),
    .sum_o    (sum_o)
  );

  assign cout_o = pre_hi[WIDTH-1];
endmodule

// File: rtl/kpg_adder_chk.sv
module kpg_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH-1:0] pre_hi,
  input logic [WIDTH-1:0] pre_lo
);
  logic [WIDTH:0] ref_sum;
  logic [WIDTH:0] cvec;

  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign cvec    = {pre_hi, cin_i};

  always_comb begin
    assert_sum_R1: assert ({cout_o, sum_o} == ref_sum)
      else $error("sum mismatch");
    assert_resolved_R7: assert (pre_hi == pre_lo)
      else $error("unresolved prefix status");
    assert_carry_R7: assert ((sum_o ^ a_i ^ b_i) == cvec[WIDTH-1:0])
      else $error("carry vector mismatch");
    if ((a_i ^ b_i) == {WIDTH{1'b1}}) begin
      assert_chain_R2: assert (cout_o == cin_i)
        else $error("propagate chain broken");
    end
    if ((a_i | b_i) == '0) begin
      assert_kill_R3: assert (!cout_o && sum_o == {{(WIDTH-1){1'b0}}, cin_i})
        else $error("kill chain broken");
    end
    if (a_i[WIDTH-1] && b_i[WIDTH-1]) begin
      assert_top_gen_R4: assert (cout_o)
        else $error("top generate lost");
    end
  end
endmodule

bind kpg_adder kpg_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .pre_hi (pre_hi),
  .pre_lo (pre_lo)
);

// File: tb/kpg_adder_tb.sv
module kpg_adder_tb;
  import kpg_adder_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W16 = 16;
  localparam int W8  = 8;
  localparam int N8  = 1 << (2 * W8 + 1);
  localparam int WDOG_CYCLES = 190000;

  typedef struct packed {
    logic [W16-1:0] a16;
    logic [W16-1:0] b16;
    logic           c16;
    logic [W8-1:0]  a8;
    logic [W8-1:0]  b8;
    logic           c8;
    logic [W16:0]   exp16;
    logic [W8:0]    exp8;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W16-1:0] a16 = '0, b16 = '0;
  logic           c16 = 1'b0;
  logic [W8-1:0]  a8 = '0, b8 = '0;
  logic           c8 = 1'b0;
  logic [W16-1:0] s16_ks, s16_sk;
  logic           co16_ks, co16_sk;
  logic [W8-1:0]  s8_ks, s8_sk;
  logic           co8_ks, co8_sk;

  kpg_adder #(.WIDTH(W16), .ARCH(ARCH_KS)) u_dut (
    .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16_ks), .cout_o(co16_ks));
  kpg_adder #(.WIDTH(W16), .ARCH(ARCH_SK)) u_dut_sk (
    .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16_sk), .cout_o(co16_sk));
  kpg_adder #(.WIDTH(W8), .ARCH(ARCH_KS)) u_dut8 (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8_ks), .cout_o(co8_ks));
  kpg_adder #(.WIDTH(W8), .ARCH(ARCH_SK)) u_dut8_sk (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8_sk), .cout_o(co8_sk));

  item_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [W16:0] act,
                       input logic [W16:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W16-1:0] a, input logic [W16-1:0] b, input logic c,
                       input logic [W8-1:0] x, input logic [W8-1:0] y, input logic z);
    item_t it;
    @(posedge clk);
    a16 <= a; b16 <= b; c16 <= c;
    a8 <= x; b8 <= y; c8 <= z;
    it.a16 = a; it.b16 = b; it.c16 = c;
    it.a8 = x; it.b8 = y; it.c8 = z;
    it.exp16 = {1'b0, a} + {1'b0, b} + {{W16{1'b0}}, c};
    it.exp8  = {1'b0, x} + {1'b0, y} + {{W8{1'b0}}, z};
    sb_q.push_back(it);
  endtask

  // monitor: combinational results are due in the drive cycle
  always @(negedge clk) begin
    if (rst_ni && sb_q.size() > 0) begin
      item_t it;
      logic [W16:0] act16, act16s, cexp;
      logic [W8:0]  act8, act8s;
      it = sb_q.pop_front();
      act16  = {co16_ks, s16_ks};
      act16s = {co16_sk, s16_sk};
      act8   = {co8_ks, s8_ks};
      act8s  = {co8_sk, s8_sk};
      check(act16 == it.exp16, "R1 sum16", act16, it.exp16);
      check(act16s == it.exp16, "R6 sum16 sklansky", act16s, it.exp16);
      check(act16s == act16, "R6 shapes agree", act16s, act16);
      check(act8 == it.exp8, "R8 sum8 kogge-stone", {8'h0, act8}, {8'h0, it.exp8});
      check(act8s == it.exp8, "R8 sum8 sklansky", {8'h0, act8s}, {8'h0, it.exp8});
      cexp = {1'b0, it.exp16[W16-1:0] ^ it.a16 ^ it.b16};
      check({1'b0, s16_ks ^ it.a16 ^ it.b16} == cexp, "R7 carries",
            {1'b0, s16_ks ^ it.a16 ^ it.b16}, cexp);
      if ((it.a16 ^ it.b16) == '1)
        check(co16_ks == it.c16 && s16_ks == {W16{~it.c16}}, "R2 propagate chain",
              act16, {it.c16, {W16{~it.c16}}});
      if ((it.a16 | it.b16) == '0)
        check(act16 == {1'b0, {(W16-1){1'b0}}, it.c16}, "R3 kill chain",
              act16, {1'b0, {(W16-1){1'b0}}, it.c16});
      if (it.a16[W16-1] && it.b16[W16-1])
        check(co16_ks == 1'b1, "R4 top generate", {16'h0, co16_ks}, 17'h1);
      if (it.a16 == '1 && it.b16 == 16'h0001)
        check(act16 == {1'b1, 15'h0, it.c16}, "R5 all-ones plus one",
              act16, {1'b1, 15'h0, it.c16});
    end
  end

  initial begin
    logic [W16-1:0] ea [10];
    logic [W16-1:0] eb [10];
    logic           ec [10];
    ea = '{16'h0000, 16'h0000, 16'hffff, 16'hffff, 16'hffff,
           16'haaaa, 16'haaaa, 16'h8000, 16'hffff, 16'h0001};
    eb = '{16'h0000, 16'h0000, 16'h0001, 16'h0001, 16'h0000,
           16'h5555, 16'h5555, 16'h8000, 16'hffff, 16'hffff};
    ec = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < N8; i++) begin
      logic [W16-1:0] ra, rb;
      logic           rc;
      if (i < 10) begin
        ra = ea[i]; rb = eb[i]; rc = ec[i];
      end else begin
        ra = W16'($urandom); rb = W16'($urandom); rc = 1'($urandom);
      end
      drive(ra, rb, rc, i[7:0], i[15:8], i[16]);
    end
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule